// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is an eight-pin general-purpose I/O port on a simple single-cycle register bus. Each pin is set as an input or an output by a direction register. Output pins drive the value held in the data register. On input pins the data register follows the external level.

The data register is reached through a 1 KiB window of byte offsets. In that window, word address bits [9:2] act as a per-pin select mask. A read returns only the selected pins and a write changes only the selected output pins. Software can therefore set or clear single pins without a read-modify-write sequence. A small read-only window returns twelve identification bytes. Each output pin has a one-cycle strobe that marks a change in its driven level.

Top module: `gpioMaskedPort`

## Requirements
- R1: The port has 8 pins and each register is 8 bits wide. Writes keep only write-data bits [7:0], and every read returns zero in bits [31:8].
- R2: Every byte offset from 0x000 to 0x3FF addresses the data register. The access mask bit i is address bit i+2, so the mask is address bits [9:2].
- R3: A read in the data window returns the data register ANDed with the access mask, with unselected bits reading as zero. Read data is registered and appears on the cycle after the read strobe.
- R4: A write in the data window changes only the data bits that are both selected by the mask and set as outputs. Every other data bit keeps its value.
- R5: The direction register sits at offset 0x400 (any byte of that word) and can be read back. Bit value 1 makes the pin an output and 0 makes it an input.
- R6: pinOut[i] equals data bit i when pin i is an output and is 1 when pin i is an input.
- R7: At each clock edge, each data bit whose pin is an input takes the level of pinIn. A pin set as an output ignores pinIn.
- R8: A read at byte offsets 0xFD0 to 0xFFF returns entry (offset-0xFD0)>>2 of the identification table, in index order 00 00 00 00 3A 91 0C 00 0D F0 05 B1. Writes to this window have no effect.
- R9: A read of an unmapped offset returns zero, and a write to an unmapped offset changes nothing. When busRd is low, busRdata is zero on the next cycle.
- R10: pinChg[i] is high for exactly one cycle whenever pinOut[i] differs from its value on the previous cycle.
- R11: Reset clears the data and direction registers. After reset, pinOut is all ones, pinChg is zero and busRdata is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 12 | Byte offset of the access |
| busWr | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRd | input | 1 | Read strobe |
| busRdata | output | 32 | Registered read data |
| pinIn | input | 8 | External pin levels |
| pinOut | output | 8 | Driven pin levels |
| pinChg | output | 8 | One-cycle change strobe per pin |

## Verification
The assertions run on every cycle and cover four things:
- writes to the data window leave unselected pins alone;
- read data carries no bits outside the mask or above bit 7, and unmapped reads return zero;
- input pins drive high after a direction write;
- the change strobe agrees with the pin history.

Input capture, exact masked read values, identification bytes and the direction-switch ordering can only be shown by the bench. It does this with scenarios compared against its own register model. These mix directed cases with random traffic in which accesses overlap the changing pin levels.

// File: rtl/gpioPortPkg.sv
package gpioPortPkg;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_DATA = 2'd1,
    RD_DIR  = 2'd2,
    RD_ID   = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic       dataWr;
    logic       dirWr;
    logic       rdEn;
    rdSel_e     rdSel;
    logic [3:0] idIdx;
  } ctrlStrobe_t;

  localparam int ID_COUNT = 12;

  function automatic logic [7:0] idByte(input logic [3:0] idx);
    logic [7:0] b;
    case (idx)
      4'd4:    b = 8'h3A;
      4'd5:    b = 8'h91;
      4'd6:    b = 8'h0C;
      4'd8:    b = 8'h0D;
      4'd9:    b = 8'hF0;
      4'd10:   b = 8'h05;
      4'd11:   b = 8'hB1;
      default: b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/gpioCtrl.sv
module gpioCtrl
  import gpioPortPkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int NUM_PINS = 8
) (
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWr,
  input  logic                busRd,
  output ctrlStrobe_t         strb,
  output logic [NUM_PINS-1:0] accMask
);

  localparam logic [ADDR_W-1:0] DATA_TOP = ADDR_W'(1 << (NUM_PINS + 2));
  localparam logic [ADDR_W-3:0] DIR_WORD = (ADDR_W-2)'(1 << NUM_PINS);
  localparam logic [ADDR_W-1:0] ID_BASE  = ADDR_W'(12'hFD0);
  localparam logic [ADDR_W-1:0] ID_LAST  = ADDR_W'(12'hFFF);

  logic              inData;
  logic              inDir;
  logic              inId;
  logic [ADDR_W-1:0] idOff;

  assign inData  = busAddr < DATA_TOP;
  assign inDir   = busAddr[ADDR_W-1:2] == DIR_WORD;
  assign inId    = (busAddr >= ID_BASE) && (busAddr <= ID_LAST);
  assign idOff   = busAddr - ID_BASE;
  assign accMask = busAddr[NUM_PINS+1:2];

  always_comb begin
    strb.dataWr = busWr && inData;
    strb.dirWr  = busWr && inDir;
    strb.rdEn   = busRd;
    strb.idIdx  = 4'(idOff >> 2);
    if (inData)     strb.rdSel = RD_DATA;
    else if (inDir) strb.rdSel = RD_DIR;
    else if (inId)  strb.rdSel = RD_ID;
    else            strb.rdSel = RD_NONE;
  end

endmodule

// File: rtl/gpioDatapath.sv
module gpioDatapath
  import gpioPortPkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strb,
  input  logic [NUM_PINS-1:0] accMask,
  input  logic [NUM_PINS-1:0] wrVal,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinChg,
  output logic [DATA_W-1:0]   rdData
);

  logic [NUM_PINS-1:0] dataQ;
  logic [NUM_PINS-1:0] dirQ;
  logic [NUM_PINS-1:0] dataNext;
  logic [NUM_PINS-1:0] driveLvl;
  logic [NUM_PINS-1:0] prevLvl;
  logic [DATA_W-1:0]   rdNext;
  logic [DATA_W-1:0]   rdQ;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic wrHit;
    assign wrHit       = strb.dataWr && accMask[i] && dirQ[i];
    assign dataNext[i] = !dirQ[i] ? pinIn[i] : (wrHit ? wrVal[i] : dataQ[i]);
    assign driveLvl[i] = dirQ[i] ? dataQ[i] : 1'b1;
  end

  always_comb begin
    case (strb.rdSel)
      RD_DATA: rdNext = DATA_W'(dataQ & accMask);
      RD_DIR:  rdNext = DATA_W'(dirQ);
      RD_ID:   rdNext = DATA_W'(idByte(strb.idIdx));
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataQ   <= '0;
      dirQ    <= '0;
      prevLvl <= '1;
      rdQ     <= '0;
    end else begin
      dataQ   <= dataNext;
      if (strb.dirWr) dirQ <= wrVal;
      prevLvl <= driveLvl;
      rdQ     <= strb.rdEn ? rdNext : '0;
    end
  end

  assign pinOut = driveLvl;
  assign pinChg = driveLvl ^ prevLvl;
  assign rdData = rdQ;

endmodule

// File: rtl/gpioMaskedPort.sv
module gpioMaskedPort
  import gpioPortPkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int NUM_PINS = 8,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWr,
  input  logic [DATA_W-1:0]   busWdata,
  input  logic                busRd,
  output logic [DATA_W-1:0]   busRdata,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinChg
);

  ctrlStrobe_t         strb;
  logic [NUM_PINS-1:0] accMask;
  logic                unusedWdataHi;

  assign unusedWdataHi = ^busWdata[DATA_W-1:NUM_PINS];

  gpioCtrl #(.ADDR_W(ADDR_W), .NUM_PINS(NUM_PINS)) u_ctrl (
    .busAddr (busAddr),
    .busWr   (busWr),
    .busRd   (busRd),
    .strb    (strb),
    .accMask (accMask)
  );

  gpioDatapath #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .accMask (accMask),
    .wrVal   (busWdata[NUM_PINS-1:0]),
    .pinIn   (pinIn),
    .pinOut  (pinOut),
    .pinChg  (pinChg),
    .rdData  (busRdata)
  );

endmodule

// File: rtl/gpioPortChk.sv
module gpioPortChk #(
  parameter int ADDR_W   = 12,
  parameter int NUM_PINS = 8,
  parameter int DATA_W   = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   busAddr,
  input logic                busWr,
  input logic [DATA_W-1:0]   busWdata,
  input logic                busRd,
  input logic [DATA_W-1:0]   busRdata,
  input logic [NUM_PINS-1:0] pinOut,
  input logic [NUM_PINS-1:0] pinChg
);

  logic inWin;
  logic dirHit;
  logic idHit;

  assign inWin  = busAddr < ADDR_W'(1 << (NUM_PINS + 2));
  assign dirHit = busAddr[ADDR_W-1:2] == (ADDR_W-2)'(1 << NUM_PINS);
  assign idHit  = busAddr >= ADDR_W'(12'hFD0);

  AST_WRITE_KEEPS_UNSELECTED: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && inWin) |=> (((pinOut ^ $past(pinOut)) & ~$past(busAddr[NUM_PINS+1:2])) == '0)); // R4

  AST_READ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && inWin) |=> ((busRdata & ~DATA_W'($past(busAddr[NUM_PINS+1:2]))) == '0)); // R3

  AST_READ_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    busRd |=> (busRdata[DATA_W-1:NUM_PINS] == '0)); // R1

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (!busRd || !(inWin || dirHit || idHit)) |=> (busRdata == '0)); // R9

  AST_INPUT_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && dirHit) |=> ((pinOut | $past(busWdata[NUM_PINS-1:0])) == '1)); // R6

  AST_CHANGE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (pinChg == (pinOut ^ $past(pinOut)))); // R10

endmodule

bind gpioMaskedPort gpioPortChk #(.ADDR_W(ADDR_W), .NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWr    (busWr),
  .busWdata (busWdata),
  .busRd    (busRd),
  .busRdata (busRdata),
  .pinOut   (pinOut),
  .pinChg   (pinChg)
);

// File: tb/tb_gpioMaskedPort.sv
module tb_gpioMaskedPort;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWr = 1'b0;
  logic [31:0] busWdata = '0;
  logic        busRd = 1'b0;
  logic [31:0] busRdata;
  logic [7:0]  pinIn = '0;
  logic [7:0]  pinOut;
  logic [7:0]  pinChg;

  int checks = 0;
  int fails  = 0;
  logic [7:0] mData = '0;
  logic [7:0] mDir  = '0;

  always #4 clk = ~clk;

  gpioMaskedPort dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busWdata(busWdata),
    .busRd(busRd), .busRdata(busRdata), .pinIn(pinIn), .pinOut(pinOut), .pinChg(pinChg)
  );

  function automatic logic [7:0] idRef(input int k);
    case (k)
      4: return 8'h3A;  5: return 8'h91;  6: return 8'h0C;
      8: return 8'h0D;  9: return 8'hF0;  10: return 8'h05; 11: return 8'hB1;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [31:0] refRead(input logic [11:0] a);
    if (a < 12'h400)            return {24'h0, mData & a[9:2]};
    else if (a[11:2] == 10'h100) return {24'h0, mDir};
    else if (a >= 12'hFD0)       return {24'h0, idRef(int'((a - 12'hFD0) >> 2))};
    return 32'h0;
  endfunction

  function automatic logic [7:0] refOut(input logic [7:0] d, input logic [7:0] r);
    return (d & r) | ~r;
  endfunction

  function automatic string regionTag(input logic [11:0] a);
    if (a < 12'h400)             return "R3";
    else if (a[11:2] == 10'h100) return "R5";
    else if (a >= 12'hFD0)       return "R8";
    return "R9";
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic wr, input logic rd, input logic [11:0] a, input logic [31:0] wd);
    logic [31:0] expRd;
    logic [7:0]  oldOut, nData, nDir, m;
    @(negedge clk);
    busWr = wr; busRd = rd; busAddr = a; busWdata = wd;
    expRd  = rd ? refRead(a) : 32'h0;
    oldOut = refOut(mData, mDir);
    nData  = (mData & mDir) | (pinIn & ~mDir);
    nDir   = mDir;
    if (wr && a < 12'h400) begin
      m = a[9:2] & mDir;
      nData = (nData & ~m) | (wd[7:0] & m);
    end
    if (wr && a[11:2] == 10'h100) nDir = wd[7:0];
    @(posedge clk);
    #2;
    mData = nData; mDir = nDir;
    check(rd ? regionTag(a) : "R9", busRdata, expRd);
    check("R6", {24'h0, pinOut}, {24'h0, refOut(mData, mDir)});
    check("R10", {24'h0, pinChg}, {24'h0, refOut(mData, mDir) ^ oldOut});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(posedge clk);
    #2;
    // R11 reset state
    check("R11", {24'h0, pinOut}, 32'hFF);
    check("R11", {24'h0, pinChg}, 32'h0);
    check("R11", busRdata, 32'h0);
    @(negedge clk); rstN = 1'b1;

    cyc(1'b0, 1'b1, 12'h3FC, '0);                 // R11 data reads zero
    cyc(1'b1, 1'b0, 12'h400, 32'hFFFF_FF0F);      // R1 upper bits dropped, R5
    cyc(1'b0, 1'b1, 12'h402, '0);                 // R5 any byte of the word
    cyc(1'b1, 1'b0, 12'h3FC, 32'h0000_00A5);      // R4 only outputs change
    cyc(1'b0, 1'b1, 12'h3FC, '0);
    cyc(1'b1, 1'b0, 12'h004, 32'h0000_0000);      // R2 mask 0x01 clears bit 0 only
    cyc(1'b0, 1'b1, 12'h00C, '0);                 // R3 mask 0x03
    pinIn = 8'hC3;                                // R7 capture inputs, outputs ignore
    cyc(1'b0, 1'b0, 12'h000, '0);
    cyc(1'b0, 1'b1, 12'h3FF, '0);
    cyc(1'b1, 1'b0, 12'h3FC, 32'h0000_0000);      // R4 write cannot touch input bits
    cyc(1'b0, 1'b1, 12'h3FC, '0);
    for (int k = 0; k < 12; k++) cyc(1'b0, 1'b1, 12'hFD0 + 12'(4 * k), '0); // R8
    cyc(1'b0, 1'b1, 12'hFFD, '0);                 // R8 unaligned
    cyc(1'b1, 1'b0, 12'hFE0, 32'hFF);             // R8 write ignored
    cyc(1'b1, 1'b0, 12'h404, 32'h0000_00FF);      // R9 unmapped write ignored
    cyc(1'b0, 1'b1, 12'h400, '0);
    cyc(1'b0, 1'b1, 12'h800, '0);                 // R9 unmapped read
    cyc(1'b1, 1'b0, 12'h400, 32'h0000_00FF);      // R10 strobes on direction switch
    cyc(1'b1, 1'b0, 12'h400, 32'h0000_0000);

    for (int n = 0; n < 4000; n++) begin
      logic [11:0] a;
      int sel;
      sel = int'($urandom_range(0, 9));
      if (sel < 5)       a = 12'($urandom_range(0, 12'h3FF));
      else if (sel < 7)  a = 12'h400 + 12'($urandom_range(0, 3));
      else if (sel < 8)  a = 12'($urandom_range(12'hFD0, 12'hFFF));
      else               a = 12'($urandom_range(12'h404, 12'hFCF));
      if ($urandom_range(0, 3) == 0) pinIn = 8'($urandom);
      cyc(1'($urandom), 1'($urandom), a, $urandom);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule